// File: doc/BRIEF.md
# Stored-Program Sequencing Core

This block is a compact processor core that runs programs held in the same memory as their data. The memory has 2^W cells of W bits (256 cells of 8 bits by default). Each instruction takes three consecutive cells: an opcode, then a first address field, then a second address field. The core steps through a fixed loop of fetch, decode and execute. It keeps one working register, a program counter, an instruction register and three condition bits (greater, equal, less). Only an explicit compare instruction writes the condition bits, and the conditional jumps test them.

Arithmetic and copying work memory-to-memory on two addresses. The working register serves only the single-address load and store instructions. A run is set up by holding reset low and writing the program and its data through the load port. The run starts when reset is released. The `halted` output rises once the core stops. The peek port reads any cell at any time, so the final memory image can be inspected.

Top module: `sp_core`

## Requirements
- R1: While `rst_n` is low on a clock edge, `halted` is 0 after that edge. Each release of reset restarts execution at address 0 with the working register and all three condition bits at 0.
- R2: An instruction sits at address p, p+1 and p+2, holding the opcode, the first address X and the second address Y in that order. Unless a jump is taken, the next instruction is fetched from p+3, with the address wrapping modulo 2^W.
- R3: Opcode 9 adds the contents of X and the contents of Y modulo 2^W and writes the sum into Y. X is left unchanged.
- R4: Opcode 1 compares the contents of X and Y as unsigned values. It sets greater/equal/less to 1/0/0 when X>Y, to 0/1/0 when they are equal, and to 0/0/1 when X<Y. No other instruction changes these bits.
- R5: Opcode 2 copies cell X into the working register. Opcode 3 copies the working register into cell X. Opcode 4 copies cell X into cell Y.
- R6: Opcode 5 always continues at address X. Opcodes 6, 7 and 8 continue at X only when the greater, equal or less bit (respectively) is 1, and otherwise fall through to p+3.
- R7: Opcode 0 and every opcode above 9 stop the core. From then on `halted` stays 1, the program counter holds, and no memory cell changes.
- R8: Every instruction takes exactly five clock cycles. A program that executes n instructions, counting the one that stops it, raises `halted` on the 5n-th rising edge after reset is released.
- R9: A rising edge with `rst_n` low and `ld_en` high writes `ld_data` into cell `ld_addr`. The same request with `rst_n` high is ignored. `peek_data` always shows the contents of cell `peek_addr` without delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low; also enables loading |
| ld_en | input | 1 | Write request for the load port (honoured only in reset) |
| ld_addr | input | W | Cell written by the load port |
| ld_data | input | W | Value written by the load port |
| peek_addr | input | W | Cell shown on `peek_data` |
| peek_data | output | W | Combinational contents of cell `peek_addr` |
| halted | output | 1 | High once execution has stopped |

## Verification
A wrong internal state almost always shows up at the ports: a bad stored value, a wrong condition bit or a wrongly taken jump changes some cell in the final image. A misfetched field does the same through a wrong address. All of these are visible on the peek port as soon as the run ends. A fault in the sequencer's state count shifts the edge on which `halted` rises, so the bench compares that edge against five cycles per executed instruction. The bench checks both against a bench model of the instruction set. It runs seeded random forward-branching programs and directed cases for wrap-around addition, unsigned compare, flag persistence, undefined opcodes and the reset-only load port.

// File: rtl/sp_pkg.sv
// Shared definitions for the stored-program core: the sequencer's states,
// the opcode values and the condition-bit positions.
// Assumes the opcode values fit the memory word (W >= 4).
package sp_pkg;

    // One pass per instruction: three fetch steps, an operand read, execute.
    typedef enum logic [2:0] {
        ST_OPC  = 3'd0,
        ST_AD1  = 3'd1,
        ST_AD2  = 3'd2,
        ST_OPND = 3'd3,
        ST_EXEC = 3'd4,
        ST_STOP = 3'd5
    } seq_state_e;

    localparam int unsigned OP_HALT  = 0;
    localparam int unsigned OP_CMP   = 1;
    localparam int unsigned OP_LOAD  = 2;
    localparam int unsigned OP_STORE = 3;
    localparam int unsigned OP_MOVE  = 4;
    localparam int unsigned OP_JMP   = 5;
    localparam int unsigned OP_JGT   = 6;
    localparam int unsigned OP_JEQ   = 7;
    localparam int unsigned OP_JLT   = 8;
    localparam int unsigned OP_ADD   = 9;

    // Bit positions inside the three-bit condition code.
    localparam int CC_GT = 2;
    localparam int CC_EQ = 1;
    localparam int CC_LT = 0;

    // Cells occupied by one instruction.
    localparam int INSN_CELLS = 3;

endpackage

// File: rtl/sp_mem.sv
// Unified program/data store of 2^W cells of W bits.
// One synchronous write port, and two combinational read ports: one for the
// core and one for observation. The cells are not reset: contents survive a
// core reset, which is how programs are loaded.
module sp_mem #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         we,
    input  logic [W-1:0] waddr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] raddr,
    output logic [W-1:0] rdata,
    input  logic [W-1:0] paddr,
    output logic [W-1:0] pdata
);
    localparam int DEPTH = 1 << W;

    logic [W-1:0] cells [DEPTH];

    // Store one cell per cycle when a write is requested.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // Core read port.
    always_comb rdata = cells[raddr];

    // Observation read port.
    always_comb pdata = cells[paddr];

endmodule

// File: rtl/sp_alu.sv
// Arithmetic for the core: modular sum and unsigned three-way comparison of
// two memory operands. Purely combinational.
module sp_alu
    import sp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] opnd_x,
    input  logic [W-1:0] opnd_y,
    output logic [W-1:0] sum,
    output logic [2:0]   flags
);
    // Sum wraps at the word width.
    always_comb sum = opnd_x + opnd_y;

    // Exactly one of the three relations is true for any operand pair.
    always_comb begin
        flags        = '0;
        flags[CC_GT] = (opnd_x >  opnd_y);
        flags[CC_EQ] = (opnd_x == opnd_y);
        flags[CC_LT] = (opnd_x <  opnd_y);
    end

endmodule

// File: rtl/sp_seq.sv
// Fetch/decode/execute sequencer. Holds the program counter, the memory
// address register, the instruction register (opcode plus two address
// fields), the first-operand data register, the working register and the
// condition bits. Every instruction spends five cycles here:
//   OPC  : opcode   <- mem[pc]      ; mar <- pc+1
//   AD1  : field X  <- mem[pc+1]    ; mar <- pc+2
//   AD2  : field Y  <- mem[pc+2]    ; mar <- X
//   OPND : mdr      <- mem[X]       ; mar <- Y
//   EXEC : mem[Y] is on rd_data; act, then pc/mar <- next address
// Assumes a combinational memory read on rd_addr.
module sp_seq
    import sp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rd_data,
    input  logic [W-1:0] alu_sum,
    input  logic [2:0]   alu_flags,
    output logic [W-1:0] rd_addr,
    output logic         wr_en,
    output logic [W-1:0] wr_addr,
    output logic [W-1:0] wr_data,
    output logic [W-1:0] opnd_x,
    output logic [W-1:0] pc_q,
    output logic [2:0]   cc_q,
    output logic         halted
);
    localparam logic [W-1:0] K_CMP   = W'(OP_CMP);
    localparam logic [W-1:0] K_LOAD  = W'(OP_LOAD);
    localparam logic [W-1:0] K_STORE = W'(OP_STORE);
    localparam logic [W-1:0] K_MOVE  = W'(OP_MOVE);
    localparam logic [W-1:0] K_JMP   = W'(OP_JMP);
    localparam logic [W-1:0] K_JGT   = W'(OP_JGT);
    localparam logic [W-1:0] K_JEQ   = W'(OP_JEQ);
    localparam logic [W-1:0] K_JLT   = W'(OP_JLT);
    localparam logic [W-1:0] K_ADD   = W'(OP_ADD);
    localparam logic [W-1:0] K_STEP  = W'(INSN_CELLS);

    seq_state_e   state;
    logic [W-1:0] mar;
    logic [W-1:0] ir_op;
    logic [W-1:0] ir_x;
    logic [W-1:0] ir_y;
    logic [W-1:0] mdr;
    logic [W-1:0] work_r;

    logic         op_runs;
    logic         op_writes;
    logic         jump_taken;
    logic [W-1:0] next_pc;

    // Opcodes 1..9 execute; 0 and anything above 9 stop the core.
    always_comb op_runs = (ir_op != '0) && (ir_op <= K_ADD);

    // Instructions that write a memory cell.
    always_comb op_writes = (ir_op == K_STORE) || (ir_op == K_MOVE) || (ir_op == K_ADD);

    // Jump decision from the opcode and the stored condition bits.
    always_comb begin
        unique case (ir_op)
            K_JMP:   jump_taken = 1'b1;
            K_JGT:   jump_taken = cc_q[CC_GT];
            K_JEQ:   jump_taken = cc_q[CC_EQ];
            K_JLT:   jump_taken = cc_q[CC_LT];
            default: jump_taken = 1'b0;
        endcase
    end

    // Address of the next instruction: jump target or the following slot.
    always_comb next_pc = jump_taken ? ir_x : (pc_q + K_STEP);

    // Memory write request, only ever issued in the execute step.
    always_comb begin
        wr_en   = (state == ST_EXEC) && op_writes;
        wr_addr = (ir_op == K_STORE) ? ir_x : ir_y;
        unique case (ir_op)
            K_STORE: wr_data = work_r;
            K_MOVE:  wr_data = mdr;
            default: wr_data = alu_sum;
        endcase
    end

    // Outward views of internal registers.
    always_comb begin
        rd_addr = mar;
        opnd_x  = mdr;
        halted  = (state == ST_STOP);
    end

    // Sequencer state and architectural registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_OPC;
            pc_q   <= '0;
            mar    <= '0;
            ir_op  <= '0;
            ir_x   <= '0;
            ir_y   <= '0;
            mdr    <= '0;
            work_r <= '0;
            cc_q   <= '0;
        end else begin
            unique case (state)
                ST_OPC: begin
                    ir_op <= rd_data;
                    mar   <= pc_q + W'(1);
                    state <= ST_AD1;
                end
                ST_AD1: begin
                    ir_x  <= rd_data;
                    mar   <= pc_q + W'(2);
                    state <= ST_AD2;
                end
                ST_AD2: begin
                    ir_y  <= rd_data;
                    mar   <= ir_x;
                    state <= ST_OPND;
                end
                ST_OPND: begin
                    mdr   <= rd_data;
                    mar   <= ir_y;
                    state <= ST_EXEC;
                end
                ST_EXEC: begin
                    if (!op_runs) begin
                        state <= ST_STOP;
                    end else begin
                        if (ir_op == K_CMP) begin
                            cc_q <= alu_flags;
                        end
                        if (ir_op == K_LOAD) begin
                            work_r <= mdr;
                        end
                        pc_q  <= next_pc;
                        mar   <= next_pc;
                        state <= ST_OPC;
                    end
                end
                default: begin
                    state <= ST_STOP;
                end
            endcase
        end
    end

endmodule

// File: rtl/sp_core.sv
// Top of the stored-program core: memory, sequencer and arithmetic unit.
// The load port may write memory only while reset is held; after release
// only the core writes. The peek port observes any cell at any time.
module sp_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_en,
    input  logic [W-1:0] ld_addr,
    input  logic [W-1:0] ld_data,
    input  logic [W-1:0] peek_addr,
    output logic [W-1:0] peek_data,
    output logic         halted
);
    logic [W-1:0] rd_addr;
    logic [W-1:0] rd_data;
    logic         core_we;
    logic [W-1:0] core_waddr;
    logic [W-1:0] core_wdata;
    logic [W-1:0] opnd_x;
    logic [W-1:0] alu_sum;
    logic [2:0]   alu_flags;
    logic [W-1:0] pc;
    logic [2:0]   cc;

    logic         ld_take;
    logic         mem_we;
    logic [W-1:0] mem_waddr;
    logic [W-1:0] mem_wdata;

    // The loader owns the write port while reset is low.
    always_comb begin
        ld_take   = ld_en && !rst_n;
        mem_we    = ld_take || core_we;
        mem_waddr = ld_take ? ld_addr : core_waddr;
        mem_wdata = ld_take ? ld_data : core_wdata;
    end

    sp_mem #(.W(W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (rd_addr),
        .rdata (rd_data),
        .paddr (peek_addr),
        .pdata (peek_data)
    );

    sp_alu #(.W(W)) u_alu (
        .opnd_x (opnd_x),
        .opnd_y (rd_data),
        .sum    (alu_sum),
        .flags  (alu_flags)
    );

    sp_seq #(.W(W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_data   (rd_data),
        .alu_sum   (alu_sum),
        .alu_flags (alu_flags),
        .rd_addr   (rd_addr),
        .wr_en     (core_we),
        .wr_addr   (core_waddr),
        .wr_data   (core_wdata),
        .opnd_x    (opnd_x),
        .pc_q      (pc),
        .cc_q      (cc),
        .halted    (halted)
    );

endmodule

// File: rtl/sp_core_chk.sv
// Property checker for sp_core, attached by the bind below. Watches the
// stop status, program counter, condition bits and the core's write strobe.
module sp_core_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         halted,
    input logic [W-1:0] pc,
    input logic [2:0]   cc,
    input logic         mem_we
);
    // R4: at most one condition bit is ever set.
    p_cc_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cc));

    // R7: once stopped, the core stays stopped.
    p_halt_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R7: a stopped core writes no cell.
    p_halt_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);

    // R7: a stopped core's program counter holds.
    p_pc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pc));

    // R4: the condition bits hold while stopped.
    p_cc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(cc));

endmodule

bind sp_core sp_core_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .halted (halted),
    .pc     (pc),
    .cc     (cc),
    .mem_we (core_we)
);

// File: tb/sp_core_test.sv
// Self-checking bench: directed corner programs plus seeded random
// forward-branching programs, each compared against a bench model.
module sp_core_test;
    localparam int CLK_NS = 10;
    localparam int W      = 8;
    localparam int CELLS  = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ld_en = 1'b0;
    logic [W-1:0] ld_addr = '0;
    logic [W-1:0] ld_data = '0;
    logic [W-1:0] peek_addr = '0;
    logic [W-1:0] peek_data;
    logic         halted;

    int n_chk  = 0;
    int n_fail = 0;

    logic [7:0] img   [CELLS];
    logic [7:0] ref_m [CELLS];

    always #(CLK_NS/2) clk = ~clk;

    sp_core #(.W(W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_en     (ld_en),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .peek_addr (peek_addr),
        .peek_data (peek_data),
        .halted    (halted)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic peek(input int a, output int d);
        peek_addr = 8'(a);
        #1;
        d = int'(peek_data);
    endtask

    // Instruction-set model run on ref_m; returns instructions executed.
    task automatic model(output int steps);
        logic [7:0] pc, r, op, x, y;
        bit gt, eq, lt, done;
        for (int i = 0; i < CELLS; i++) ref_m[i] = img[i];
        pc = 0; r = 0; gt = 0; eq = 0; lt = 0; done = 0; steps = 0;
        while (!done && steps < 2000) begin
            op = ref_m[pc];
            x  = ref_m[8'(pc + 8'd1)];
            y  = ref_m[8'(pc + 8'd2)];
            steps++;
            pc = 8'(pc + 8'd3);
            case (op)
                8'd1: begin
                    gt = ref_m[x] > ref_m[y];
                    eq = ref_m[x] == ref_m[y];
                    lt = ref_m[x] < ref_m[y];
                end
                8'd2: r = ref_m[x];
                8'd3: ref_m[x] = r;
                8'd4: ref_m[y] = ref_m[x];
                8'd5: pc = x;
                8'd6: if (gt) pc = x;
                8'd7: if (eq) pc = x;
                8'd8: if (lt) pc = x;
                8'd9: ref_m[y] = 8'(ref_m[x] + ref_m[y]);
                default: done = 1;
            endcase
        end
    endtask

    // Load img under reset, run to stop, compare timing and the whole image.
    task automatic run_prog(input string tag);
        int steps, cyc, bad, first_bad, d;
        model(steps);
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < CELLS; i++) begin
            @(negedge clk);
            ld_en   = 1'b1;
            ld_addr = 8'(i);
            ld_data = img[i];
        end
        @(negedge clk);
        ld_en = 1'b0;
        peek(0, d);
        check(d == int'(img[0]), {"R9 load ", tag}, d, int'(img[0]));
        check(halted == 1'b0, {"R1 reset ", tag}, int'(halted), 0);
        rst_n = 1'b1;
        cyc = 0;
        do begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end while (!halted && cyc < 12000);
        check(cyc == 5 * steps, {"R8 R1 stop edge ", tag}, cyc, 5 * steps);
        bad = 0; first_bad = -1;
        for (int i = 0; i < CELLS; i++) begin
            peek(i, d);
            if (d != int'(ref_m[i])) begin
                bad++;
                if (first_bad < 0) first_bad = i;
            end
        end
        if (first_bad >= 0) peek(first_bad, d);
        check(bad == 0, {"R2 R3 R4 R5 R6 image ", tag},
              (first_bad < 0) ? 0 : d,
              (first_bad < 0) ? 0 : int'(ref_m[first_bad]));
    endtask

    task automatic clear_img;
        for (int i = 0; i < CELLS; i++) img[i] = 8'd0;
    endtask

    task automatic put(input int a, input int op, input int x, input int y);
        img[a] = 8'(op); img[a+1] = 8'(x); img[a+2] = 8'(y);
    endtask

    initial begin
        #(CLK_NS * 190000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int d;
        void'($urandom(32'h5EED_0C0E));

        // R3 R5: wrap-around add, load/store, move.
        clear_img;
        put(0, 2, 130, 0);     // LOAD 130
        put(3, 3, 140, 0);     // STORE 140
        put(6, 4, 130, 141);   // MOVE 130,141
        put(9, 9, 131, 132);   // ADD 131,132
        put(12, 0, 0, 0);      // HALT
        img[130] = 8'hC8; img[131] = 8'h64; img[132] = 8'hC8;
        run_prog("p1");
        peek(132, d); check(d == 44,  "R3 wrapped sum", d, 44);
        peek(131, d); check(d == 100, "R3 X unchanged", d, 100);
        peek(140, d); check(d == 200, "R5 store of loaded value", d, 200);
        peek(141, d); check(d == 200, "R5 move", d, 200);

        // R4 R6: unsigned compare steers conditional jumps.
        clear_img;
        put(0, 1, 150, 151);   // CMP 150,151 -> greater
        put(3, 8, 15, 0);      // JLT 15 (not taken)
        put(6, 7, 15, 0);      // JEQ 15 (not taken)
        put(9, 6, 18, 0);      // JGT 18 (taken)
        put(12, 0, 0, 0);
        put(15, 0, 0, 0);
        put(18, 4, 150, 160);  // MOVE 150,160
        put(21, 0, 0, 0);
        img[150] = 8'hF0; img[151] = 8'h10; img[160] = 8'h00;
        run_prog("p2");
        peek(160, d); check(d == 240, "R6 R4 greater path taken", d, 240);

        // R4 R6 R1: equal bit survives an add; store of reset-cleared register.
        clear_img;
        put(0, 1, 150, 150);   // CMP equal
        put(3, 9, 150, 151);   // ADD must not touch the bits
        put(6, 7, 12, 0);      // JEQ 12 (taken)
        put(9, 0, 0, 0);
        put(12, 3, 170, 0);    // STORE 170, register still 0
        put(15, 0, 0, 0);
        img[150] = 8'd7; img[151] = 8'd9; img[170] = 8'h55;
        run_prog("p3");
        peek(170, d); check(d == 0,  "R4 R1 flag held, register cleared", d, 0);
        peek(151, d); check(d == 16, "R3 plain sum", d, 16);

        // R7 R9: undefined opcode stops; loader ignored outside reset.
        clear_img;
        put(0, 8'hA7, 180, 181);
        put(3, 4, 180, 181);
        img[180] = 8'd1; img[181] = 8'd2;
        run_prog("p4");
        repeat (20) @(negedge clk);
        check(halted == 1'b1, "R7 stays stopped", int'(halted), 1);
        peek(181, d); check(d == 2, "R7 nothing after stop", d, 2);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = 8'd181; ld_data = 8'h99;
        @(negedge clk);
        ld_en = 1'b0;
        peek(181, d); check(d == 2, "R9 load ignored out of reset", d, 2);

        // R2 R6 R7 R8: seeded random programs with forward jumps only.
        for (int p = 0; p < 24; p++) begin
            int len;
            clear_img;
            len = 3 + int'($urandom_range(0, 9));
            for (int i = 0; i < len; i++) begin
                int k;
                k = int'($urandom_range(0, 8));
                if (k <= 5) begin
                    int ops [6] = '{2, 3, 4, 9, 1, 1};
                    put(3 * i, ops[k], 128 + int'($urandom_range(0, 127)),
                        128 + int'($urandom_range(0, 127)));
                end else begin
                    put(3 * i, 5 + int'($urandom_range(0, 3)),
                        3 * int'($urandom_range(i + 1, len)),
                        int'($urandom_range(0, 255)));
                end
            end
            if ($urandom_range(0, 1) == 1) put(3 * len, 0, 0, 0);
            else put(3 * len, 10 + int'($urandom_range(0, 245)), 0, 0);
            for (int a = 128; a < CELLS; a++) img[a] = 8'($urandom_range(0, 255));
            run_prog($sformatf("rand%0d", p));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule